// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This unit turns a segment-relative offset into a flat linear address. It keeps six segment registers. Each register has a hidden copy of the descriptor that belongs to its selector. Software loads a register by presenting a selector. The unit then reads the two-word descriptor from either the global or the local descriptor table in memory and stores it in that register's hidden copy. After the load, every access through that register is checked against the cached copy, and no table read is needed.

An access gives an offset and an access kind, and states whether it is a write. The kind picks the register implicitly: code for fetches, stack for stack references, data for everything else. An override can name any register for that one access. The unit checks three things: that the descriptor is valid, that the offset does not exceed the limit, and that writes only go to writable segments. One cycle later it returns either base plus offset or a fault code. If an access targets a register whose descriptor load is still in flight, the access is stalled until the load finishes.

Top module: `seg_xlate`

## Requirements
- R1: After reset, all six cached descriptors are invalid, `res_valid_o`, `mem_req_o`, `ld_busy_o` and `acc_stall_o` are low, and any access faults with code 01.
- R2: With no override, register selection follows `acc_kind_i`: kind 0 (fetch) uses register 0 (code), kind 1 (stack) uses register 1 (stack), and kinds 2 and 3 use register 2 (data).
- R3: When `acc_ovr_en_i` is high, `acc_ovr_seg_i` selects the register for that access only. Indices 6 and 7 name no register and fault with code 01.
- R4: A selector has two parts. Bits 12:0 are a table index, and bit 13 chooses the table (1 = local, 0 = global). The descriptor is read at table base + index*8. `mem_addr_o` holds steady while `mem_req_o` waits for `mem_rvalid_i`.
- R5: A descriptor is two 32-bit words, read in this order: first the base (at +0), then the attribute word (at +4). In the attribute word, bits 19:0 are the limit, bit 31 is valid and bit 30 is writable. `ld_busy_o` is high from the cycle after a load is accepted until the cycle after the second word is received.
- R6: An allowed access produces `res_valid_o` with `res_lin_o` = base + offset (modulo 2^32) and fault 00. The result appears in the cycle after the access is accepted.
- R7: An access through an invalid descriptor faults with code 01. This check takes priority over all others. A faulting access returns `res_lin_o` = 0.
- R8: An offset greater than the limit faults with code 10. An offset equal to the limit is allowed. The limit fault takes priority over the read-only fault.
- R9: A write through a descriptor whose writable bit is clear faults with code 11. Writes through writable descriptors, and all reads, are allowed.
- R10: An access to a register whose descriptor load is pending raises `acc_stall_o` and produces no result until the load completes. Accesses to other registers proceed without stalling.
- R11: Once a register has been loaded, accesses issue no memory requests. Changing the table contents later has no effect on translation until that register is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gtab_base_i | input | 32 | Global descriptor table base address |
| ltab_base_i | input | 32 | Local descriptor table base address |
| ld_valid_i | input | 1 | Load a segment register (accepted when not busy) |
| ld_seg_i | input | 3 | Register index to load |
| ld_sel_i | input | 14 | Selector: table bit 13, index 12:0 |
| ld_busy_o | output | 1 | Descriptor load in progress |
| mem_req_o | output | 1 | Table word read request |
| mem_addr_o | output | 32 | Table word address |
| mem_rdata_i | input | 32 | Table word data |
| mem_rvalid_i | input | 1 | Table word data valid |
| acc_valid_i | input | 1 | Access request |
| acc_kind_i | input | 2 | 0 fetch, 1 stack, 2/3 data |
| acc_write_i | input | 1 | Access is a write |
| acc_ovr_en_i | input | 1 | Use explicit register |
| acc_ovr_seg_i | input | 3 | Explicit register index |
| acc_off_i | input | 32 | Offset in segment |
| acc_stall_o | output | 1 | Access held, load pending on its register |
| res_valid_o | output | 1 | Result valid |
| res_lin_o | output | 32 | Linear address, zero on fault |
| res_fault_o | output | 2 | 00 none, 01 invalid, 10 limit, 11 read-only write |

## Verification
A wrong cached descriptor does not show up right away. It appears only when that register is next used, one cycle after the access, as a wrong linear address or a wrong fault code. For this reason the reference model compares every result against its own descriptor copies, for each register, on every clock. A stuck or mistimed load shows at the ports in one of two ways: as a wrong `mem_addr_o` at the moment a word is delivered, or as `acc_stall_o` differing from the expected pending state in the same cycle. Any mistake in priority order or in the limit boundary shows in the fault code of the very next result.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned LIM_W  = 20;
  parameter int unsigned VALID_BIT = 31;
  parameter int unsigned WRITE_BIT = 30;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_LIMIT   = 2'b10,
    FLT_RDONLY  = 2'b11
  } fault_e;

  typedef struct packed {
    logic              valid;
    logic              writable;
    logic [LIM_W-1:0]  limit;
    logic [ADDR_W-1:0] base;
  } desc_t;
endpackage

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned IDX_W = 13,
  localparam int unsigned SEL_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] gtab_base_i,
  input  logic [ADDR_W-1:0] ltab_base_i,
  input  logic              ld_valid_i,
  input  logic [SEG_W-1:0]  ld_seg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  output logic              busy_o,
  output logic [SEG_W-1:0]  busy_seg_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              wr_en_o,
  output logic [SEG_W-1:0]  wr_seg_o,
  output desc_t             wr_desc_o
);
  typedef enum logic [1:0] {L_IDLE, L_BASE, L_ATTR} ld_state_e;

  ld_state_e         state_q;
  logic [SEG_W-1:0]  seg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] tab_base;
  logic              unused_attr;

  assign tab_base = ld_sel_i[IDX_W] ? ltab_base_i : gtab_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= L_IDLE;
      seg_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        L_IDLE: if (ld_valid_i) begin
          seg_q   <= ld_seg_i;
          addr_q  <= tab_base + {{(ADDR_W-IDX_W-3){1'b0}}, ld_sel_i[IDX_W-1:0], 3'b000};
          state_q <= L_BASE;
        end
        L_BASE: if (mem_rvalid_i) begin
          base_q  <= mem_rdata_i;
          addr_q  <= addr_q + ADDR_W'(4);
          state_q <= L_ATTR;
        end
        L_ATTR: if (mem_rvalid_i) state_q <= L_IDLE;
        default: state_q <= L_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != L_IDLE);
  assign busy_seg_o = seg_q;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign wr_en_o    = (state_q == L_ATTR) && mem_rvalid_i;
  assign wr_seg_o   = seg_q;
  assign wr_desc_o  = '{valid:    mem_rdata_i[VALID_BIT],
                        writable: mem_rdata_i[WRITE_BIT],
                        limit:    mem_rdata_i[LIM_W-1:0],
                        base:     base_q};
  assign unused_attr = ^mem_rdata_i[WRITE_BIT-1:LIM_W];

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !busy_o);
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_N = 6,
  localparam int unsigned SEG_W = $clog2(SEG_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  desc_t            wr_desc_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output desc_t            rd_desc_o
);
  desc_t desc_q [SEG_N];

  for (genvar g = 0; g < SEG_N; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  desc_q[g] <= '0;
      else if (wr_en_i && wr_seg_i == SEG_W'(g))    desc_q[g] <= wr_desc_i;
    end
  end

  // out-of-range index reads as an invalid descriptor
  always_comb begin
    rd_desc_o = '0;
    for (int i = 0; i < SEG_N; i++)
      if (rd_seg_i == SEG_W'(i)) rd_desc_o = desc_q[i];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  desc_t             desc_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              write_i,
  output fault_e            fault_o,
  output logic [ADDR_W-1:0] lin_o
);
  logic over_lim;
  assign over_lim = off_i > ADDR_W'(desc_i.limit);

  always_comb begin
    lin_o = '0;
    if (!desc_i.valid)                    fault_o = FLT_INVALID;
    else if (over_lim)                    fault_o = FLT_LIMIT;
    else if (write_i && !desc_i.writable) fault_o = FLT_RDONLY;
    else begin
      fault_o = FLT_NONE;
      lin_o   = desc_i.base + off_i;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_N = 6,
  parameter int unsigned IDX_W = 13,
  localparam int unsigned SEG_W = $clog2(SEG_N),
  localparam int unsigned SEL_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] gtab_base_i,
  input  logic [ADDR_W-1:0] ltab_base_i,
  input  logic              ld_valid_i,
  input  logic [SEG_W-1:0]  ld_seg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  output logic              ld_busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_write_i,
  input  logic              acc_ovr_en_i,
  input  logic [SEG_W-1:0]  acc_ovr_seg_i,
  input  logic [ADDR_W-1:0] acc_off_i,
  output logic              acc_stall_o,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_lin_o,
  output logic [1:0]        res_fault_o
);
  localparam logic [SEG_W-1:0] CODE_SEG  = SEG_W'(0);
  localparam logic [SEG_W-1:0] STACK_SEG = SEG_W'(1);
  localparam logic [SEG_W-1:0] DATA_SEG  = SEG_W'(2);

  logic [SEG_W-1:0]  busy_seg, wr_seg, acc_seg;
  logic              wr_en, pending;
  desc_t             wr_desc, rd_desc;
  fault_e            fault;
  logic [ADDR_W-1:0] lin;

  seg_desc_loader #(.SEG_W(SEG_W), .IDX_W(IDX_W)) u_loader (
    .clk_i, .rst_ni, .gtab_base_i, .ltab_base_i,
    .ld_valid_i, .ld_seg_i, .ld_sel_i,
    .busy_o(ld_busy_o), .busy_seg_o(busy_seg),
    .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_rvalid_i,
    .wr_en_o(wr_en), .wr_seg_o(wr_seg), .wr_desc_o(wr_desc)
  );

  seg_desc_cache #(.SEG_N(SEG_N)) u_cache (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_desc_i(wr_desc),
    .rd_seg_i(acc_seg), .rd_desc_o(rd_desc)
  );

  seg_check u_check (
    .desc_i(rd_desc), .off_i(acc_off_i), .write_i(acc_write_i),
    .fault_o(fault), .lin_o(lin)
  );

  always_comb begin
    if (acc_ovr_en_i)           acc_seg = acc_ovr_seg_i;
    else if (acc_kind_i == 2'd0) acc_seg = CODE_SEG;
    else if (acc_kind_i == 2'd1) acc_seg = STACK_SEG;
    else                         acc_seg = DATA_SEG;
  end

  assign pending     = ld_busy_o && (busy_seg == acc_seg);
  assign acc_stall_o = acc_valid_i && pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_lin_o   <= '0;
      res_fault_o <= FLT_NONE;
    end else begin
      res_valid_o <= acc_valid_i && !pending;
      if (acc_valid_i && !pending) begin
        res_lin_o   <= lin;
        res_fault_o <= fault;
      end
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stall_o |=> !res_valid_o);

  assert_result_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_stall_o) |=> res_valid_o);

  assert_fault_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o != FLT_NONE) |-> (res_lin_o == '0));
endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  localparam logic [31:0] GTAB = 32'h0001_0000;
  localparam logic [31:0] LTAB = 32'h0002_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [2:0]  ld_seg_i = '0;
  logic [13:0] ld_sel_i = '0;
  logic        ld_busy_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [1:0]  acc_kind_i = '0;
  logic        acc_write_i = 1'b0;
  logic        acc_ovr_en_i = 1'b0;
  logic [2:0]  acc_ovr_seg_i = '0;
  logic [31:0] acc_off_i = '0;
  logic        acc_stall_o, res_valid_o;
  logic [31:0] res_lin_o;
  logic [1:0]  res_fault_o;

  always #4 clk_i = ~clk_i;

  seg_xlate dut_i (
    .clk_i, .rst_ni, .gtab_base_i(GTAB), .ltab_base_i(LTAB),
    .ld_valid_i, .ld_seg_i, .ld_sel_i, .ld_busy_o,
    .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_rvalid_i,
    .acc_valid_i, .acc_kind_i, .acc_write_i, .acc_ovr_en_i, .acc_ovr_seg_i,
    .acc_off_i, .acc_stall_o, .res_valid_o, .res_lin_o, .res_fault_o
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] m_base [8];
  logic [19:0] m_lim [8];
  bit          m_val [8];
  bit          m_wr [8];
  bit          pend [8];
  int          ld_s, wcnt, lat, req_cnt;
  logic [31:0] ld_addr, cap_base, cap_attr;
  bit          commit;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int resolve();
    if (acc_ovr_en_i) return int'(acc_ovr_seg_i);
    if (acc_kind_i == 2'd0) return 0;
    if (acc_kind_i == 2'd1) return 1;
    return 2;
  endfunction

  task automatic model(int s, output logic [31:0] l, output logic [1:0] f);
    l = 32'h0;
    if (s >= 6 || !m_val[s])                   f = 2'b01;
    else if (acc_off_i > {12'h0, m_lim[s]})    f = 2'b10;
    else if (acc_write_i && !m_wr[s])          f = 2'b11;
    else begin f = 2'b00; l = m_base[s] + acc_off_i; end
  endtask

  function automatic string ftag(logic [1:0] f);
    case (f)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  // one clock of the reference model, compared on every cycle
  task automatic tick();
    int s;
    logic [31:0] xl;
    logic [1:0] xf;
    bit xs, xv;
    #1;
    s  = resolve();
    xs = acc_valid_i && (s < 6) && pend[s];
    chk(acc_stall_o === xs, "R10 stall", {31'h0, acc_stall_o}, {31'h0, xs});
    xv = acc_valid_i && !xs;
    model(s, xl, xf);
    if (ld_valid_i && !ld_busy_o) begin
      ld_s = int'(ld_seg_i);
      pend[ld_s] = 1'b1;
      ld_addr = (ld_sel_i[13] ? LTAB : GTAB) + {16'h0, ld_sel_i[12:0], 3'b000};
      wcnt = 0;
      lat = 0;
    end
    @(negedge clk_i);
    chk(res_valid_o === xv, "R6 valid", {31'h0, res_valid_o}, {31'h0, xv});
    if (xv) begin
      chk(res_lin_o === xl, ftag(xf), res_lin_o, xl);
      chk(res_fault_o === xf, ftag(xf), {30'h0, res_fault_o}, {30'h0, xf});
    end
    if (commit) begin
      m_base[ld_s] = cap_base;
      m_lim[ld_s]  = cap_attr[19:0];
      m_val[ld_s]  = cap_attr[31];
      m_wr[ld_s]   = cap_attr[30];
      pend[ld_s]   = 1'b0;
      commit = 1'b0;
    end
    ld_valid_i = 1'b0;
    mem_rvalid_i = 1'b0;
    if (mem_req_o) begin
      req_cnt++;
      lat++;
      if (lat == 2) begin
        lat = 0;
        chk(mem_addr_o === ld_addr + 32'(wcnt * 4), "R4 addr", mem_addr_o, ld_addr + 32'(wcnt * 4));
        mem_rvalid_i = 1'b1;
        mem_rdata_i = mem_m.exists(mem_addr_o) ? mem_m[mem_addr_o] : 32'h0;
        if (wcnt == 0) cap_base = mem_rdata_i;
        else begin cap_attr = mem_rdata_i; commit = 1'b1; end
        wcnt++;
      end
    end
  endtask

  function automatic bit any_pend();
    for (int i = 0; i < 8; i++) if (pend[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic start_load(int seg, logic [13:0] sel);
    ld_valid_i = 1'b1;
    ld_seg_i = 3'(seg);
    ld_sel_i = sel;
    tick();
    chk(ld_busy_o === 1'b1, "R5 busy after accept", {31'h0, ld_busy_o}, 32'h1);
  endtask

  task automatic load(int seg, logic [13:0] sel);
    start_load(seg, sel);
    while (any_pend()) tick();
    chk(ld_busy_o === 1'b0, "R5 busy after done", {31'h0, ld_busy_o}, 32'h0);
  endtask

  task automatic access(string tag, logic [1:0] kind, logic wr, logic oen, logic [2:0] oseg,
                        logic [31:0] off, logic [31:0] xl, logic [1:0] xf);
    acc_valid_i = 1'b1;
    acc_kind_i = kind;
    acc_write_i = wr;
    acc_ovr_en_i = oen;
    acc_ovr_seg_i = oseg;
    acc_off_i = off;
    tick();
    acc_valid_i = 1'b0;
    chk(res_valid_o === 1'b1, tag, {31'h0, res_valid_o}, 32'h1);
    chk(res_lin_o === xl, tag, res_lin_o, xl);
    chk(res_fault_o === xf, tag, {30'h0, res_fault_o}, {30'h0, xf});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 0; m_wr[i] = 0; pend[i] = 0;
    end
    commit = 0; req_cnt = 0; wcnt = 0; lat = 0; ld_s = 0;
    ld_addr = '0; cap_base = '0; cap_attr = '0;
    mem_m[32'h0001_0028] = 32'h1000_0000; mem_m[32'h0001_002C] = 32'hC000_00FF;
    mem_m[32'h0002_0018] = 32'h0000_2000; mem_m[32'h0002_001C] = 32'h800F_FFFF;
    mem_m[32'h0001_FFF8] = 32'h3000_0000; mem_m[32'h0001_FFFC] = 32'h4000_0010;
    mem_m[32'h0001_0038] = 32'hFFFF_FF00; mem_m[32'h0001_003C] = 32'hC000_0FFF;
    mem_m[32'h0002_0008] = 32'h0000_4000; mem_m[32'h0002_000C] = 32'h8000_0000;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(res_valid_o === 1'b0, "R1 res_valid", {31'h0, res_valid_o}, 32'h0);
    chk(mem_req_o === 1'b0, "R1 mem_req", {31'h0, mem_req_o}, 32'h0);
    chk(ld_busy_o === 1'b0, "R1 busy", {31'h0, ld_busy_o}, 32'h0);
    chk(acc_stall_o === 1'b0, "R1 stall", {31'h0, acc_stall_o}, 32'h0);
    access("R1 unloaded data", 2'd2, 1'b0, 1'b0, 3'd0, 32'h0, 32'h0, 2'b01);
    access("R1 unloaded code", 2'd0, 1'b0, 1'b0, 3'd0, 32'h4, 32'h0, 2'b01);

    // data register from the global table, index 5
    load(2, {1'b0, 13'd5});
    access("R2 data read", 2'd2, 1'b0, 1'b0, 3'd0, 32'h10, 32'h1000_0010, 2'b00);
    access("R8 offset at limit", 2'd2, 1'b0, 1'b0, 3'd0, 32'hFF, 32'h1000_00FF, 2'b00);
    access("R8 offset past limit", 2'd2, 1'b0, 1'b0, 3'd0, 32'h100, 32'h0, 2'b10);
    access("R9 write to writable", 2'd2, 1'b1, 1'b0, 3'd0, 32'h4, 32'h1000_0004, 2'b00);

    // code register from the local table, fetch stalls while its load runs
    start_load(0, {1'b1, 13'd3});
    acc_valid_i = 1'b1; acc_kind_i = 2'd0; acc_write_i = 1'b0; acc_ovr_en_i = 1'b0;
    acc_off_i = 32'h40;
    #1;
    chk(acc_stall_o === 1'b1, "R10 stall on pending", {31'h0, acc_stall_o}, 32'h1);
    while (pend[0]) tick();
    tick();
    acc_valid_i = 1'b0;
    chk(res_lin_o === 32'h0000_2040, "R10 released fetch", res_lin_o, 32'h0000_2040);
    chk(res_fault_o === 2'b00, "R2 fetch uses code", {30'h0, res_fault_o}, 32'h0);
    access("R3 override write read-only", 2'd2, 1'b1, 1'b1, 3'd0, 32'h8, 32'h0, 2'b11);
    access("R3 override read", 2'd2, 1'b0, 1'b1, 3'd0, 32'h8, 32'h0000_2008, 2'b00);
    access("R2 override is one access", 2'd2, 1'b0, 1'b0, 3'd0, 32'h8, 32'h1000_0008, 2'b00);
    access("R8 limit over read-only", 2'd0, 1'b1, 1'b1, 3'd0, 32'h10_0000, 32'h0, 2'b10);

    // stack register with an invalid descriptor at the top global index
    start_load(1, {1'b0, 13'h1FFF});
    acc_valid_i = 1'b1; acc_kind_i = 2'd2; acc_write_i = 1'b0; acc_ovr_en_i = 1'b0;
    acc_off_i = 32'h0;
    #1;
    chk(acc_stall_o === 1'b0, "R10 other register proceeds", {31'h0, acc_stall_o}, 32'h0);
    tick();
    acc_valid_i = 1'b0;
    chk(res_lin_o === 32'h1000_0000, "R10 other register result", res_lin_o, 32'h1000_0000);
    while (any_pend()) tick();
    access("R7 invalid stack", 2'd1, 1'b0, 1'b0, 3'd0, 32'h0, 32'h0, 2'b01);
    access("R7 invalid has priority", 2'd1, 1'b1, 1'b0, 3'd0, 32'h20, 32'h0, 2'b01);

    access("R3 index 6 unmapped", 2'd2, 1'b0, 1'b1, 3'd6, 32'h0, 32'h0, 2'b01);
    access("R3 index 3 unloaded", 2'd2, 1'b0, 1'b1, 3'd3, 32'h0, 32'h0, 2'b01);
    load(3, {1'b1, 13'd1});
    access("R5 zero limit ok", 2'd2, 1'b0, 1'b1, 3'd3, 32'h0, 32'h0000_4000, 2'b00);
    access("R5 zero limit past", 2'd2, 1'b0, 1'b1, 3'd3, 32'h1, 32'h0, 2'b10);

    // cached copy survives table edits; no memory traffic on access
    mem_m[32'h0001_002C] = 32'h0;
    req_cnt = 0;
    access("R11 cached base", 2'd2, 1'b0, 1'b0, 3'd0, 32'h20, 32'h1000_0020, 2'b00);
    access("R11 cached attr", 2'd3, 1'b1, 1'b0, 3'd0, 32'h30, 32'h1000_0030, 2'b00);
    chk(req_cnt == 0, "R11 no memory requests", 32'(req_cnt), 32'h0);

    load(2, {1'b0, 13'd7});
    access("R6 wrap", 2'd2, 1'b0, 1'b0, 3'd0, 32'h200, 32'h0000_0100, 2'b00);
    access("R2 kind 3 is data", 2'd3, 1'b0, 1'b0, 3'd0, 32'h0, 32'hFFFF_FF00, 2'b00);
    repeat (2) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule